// File: doc/BRIEF.md
# Cycle-Steal DMA Channel Engine

This block is one channel of a cycle-stealing DMA controller. Software programs a source pointer, a destination pointer, a count reload value and a control word through a narrow write port. Each time the external arbiter grants the channel with a one-cycle start pulse, the channel performs a single transfer of one 8-bit or 16-bit unit. The transfer is a read bus cycle, a capture cycle and a write bus cycle. Either the source or the destination address may step forward after each unit, or both may stay fixed. A 16-bit working counter counts the transfers. When it underflows, the channel pulses an interrupt request. In single mode the channel then disables itself; in repeat mode it reloads the counter and keeps running.

The working forward pointer and the working counter are loaded only on the first granted transfer after the enable bit goes from 0 to 1. Later transfers continue from the working copies, so rewriting a pointer while the channel is enabled does not move an address stream that is already running. Register writes that arrive during a transfer are held in a one-entry slot and applied when that transfer finishes.

Top module: `dma_xfer_channel`

## Requirements
- R1: A start pulse sampled while the channel is idle and enabled begins a transfer. `bus_rd` is high in the next cycle, the cycle after that is a capture cycle with both strobes low, and `bus_wr` is high in the third cycle. `busy` is high for exactly those three cycles.
- R2: A start pulse is ignored while the channel is disabled or while a transfer is in progress.
- R3: On the first transfer after the enable bit changes from 0 to 1, the working forward pointer is loaded from whichever pointer is marked forward, and the working counter is loaded from the reload value.
- R4: After each transfer the forward address advances by 1 in 8-bit mode or by 2 in 16-bit mode, wrapping within 20 bits. A fixed address is presented unchanged on every transfer.
- R5: The write cycle carries the data returned by the read cycle. In 8-bit mode bits 15:8 of `bus_wdata` are zero. `bus_wide` shows the unit size of the running transfer.
- R6: A reload value of N gives N+1 transfers per counter round. `irq` is high for one cycle, in the cycle after the write cycle of the transfer that found the counter at zero.
- R7: In single mode (control bit 2 = 0), underflow clears the enable bit, which `active` shows. In repeat mode (bit 2 = 1), the counter reloads and the channel stays enabled.
- R8: Register write selectors are 0 = source pointer, 1 = destination pointer, 2 = reload value (low 16 bits), 3 = control. The control bits are bit0 enable, bit1 16-bit unit, bit2 repeat, bit3 source forward and bit4 destination forward. A control write with both bit3 and bit4 set is ignored as a whole.
- R9: A register write made during the read or capture cycle of a transfer takes effect when that transfer ends. Writing 0 to the enable bit stops the channel in either mode, so later start pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector |
| wr_data | input | 20 | Register write data |
| start | input | 1 | Grant pulse from the arbiter |
| bus_addr | output | 20 | Bus address for the read or write cycle |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wide | output | 1 | 1 for 16-bit unit, 0 for 8-bit unit |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid in the cycle `bus_rd` is high |
| busy | output | 1 | Transfer in progress |
| active | output | 1 | Current enable bit |
| irq | output | 1 | Counter underflow pulse |

## Verification
The assertions assume a bus that returns read data in the same cycle as the read strobe and never stalls. They also assume that reset clears every output to zero. The stimulus holds the deferred slot to at most one register write per transfer. It never places a write in the same cycle as a start pulse, and it never writes during the write cycle while an earlier write is still waiting. Under these limits the phase order, the one-cycle interrupt, the stable unit size during a transfer and the zeroed upper byte all follow from the design's ports alone. The bench's behavioural model shadows all outputs on every cycle, including the pointer wrap at the top of the 20-bit space.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_HOLD  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;

  // bit0 = en, bit1 = wide, bit2 = rpt, bit3 = src_fwd, bit4 = dst_fwd
  typedef struct packed {
    logic dst_fwd;
    logic src_fwd;
    logic rpt;
    logic wide;
    logic en;
  } chan_ctrl_t;

  localparam int CTRL_W = 5;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_RLD = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          busy,
  input  logic          done,
  input  logic          sgl_end,
  input  logic          launch,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] rld,
  output chan_ctrl_t    ctrl,
  output logic          first
);

  logic          pend_v;
  logic [1:0]    pend_sel;
  logic [AW-1:0] pend_data;

  logic          use_v;
  logic [1:0]    use_sel;
  logic [AW-1:0] use_data;
  chan_ctrl_t    new_ctrl;
  logic          en_eff;
  logic          hold_wr;

  // a write in the read or capture cycle is parked; writes in the
  // write cycle or while idle apply directly
  assign hold_wr = wr_en && busy && !done;
  assign en_eff  = ctrl.en && !sgl_end;

  always_comb begin
    use_v    = 1'b0;
    use_sel  = wr_sel;
    use_data = wr_data;
    if (wr_en && !hold_wr) begin
      use_v = 1'b1;
    end else if (done && pend_v) begin
      use_v    = 1'b1;
      use_sel  = pend_sel;
      use_data = pend_data;
    end
    new_ctrl = chan_ctrl_t'(use_data[CTRL_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_ptr   <= '0;
      dst_ptr   <= '0;
      rld       <= '0;
      ctrl      <= '0;
      first     <= 1'b0;
      pend_v    <= 1'b0;
      pend_sel  <= '0;
      pend_data <= '0;
    end else begin
      if (hold_wr) begin
        pend_v    <= 1'b1;
        pend_sel  <= wr_sel;
        pend_data <= wr_data;
      end else if (done) begin
        pend_v <= 1'b0;
      end

      if (launch)  first   <= 1'b0;
      if (sgl_end) ctrl.en <= 1'b0;

      if (use_v) begin
        case (use_sel)
          SEL_SRC: src_ptr <= use_data;
          SEL_DST: dst_ptr <= use_data;
          SEL_RLD: rld     <= use_data[CW-1:0];
          default: begin
            if (!(new_ctrl.src_fwd && new_ctrl.dst_fwd)) begin
              ctrl <= new_ctrl;
              if (new_ctrl.en && !en_eff) first <= 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
  import dma_chan_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          first,
  input  logic          done,
  input  chan_ctrl_t    ctrl,
  input  logic [AW-1:0] src_ptr,
  input  logic [AW-1:0] dst_ptr,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr
);

  logic [AW-1:0] cur;
  logic [AW-1:0] step;

  assign step    = ctrl.wide ? AW'(2) : AW'(1);
  assign rd_addr = (ctrl.src_fwd && !first) ? cur : src_ptr;
  assign wr_addr = ctrl.dst_fwd ? cur : dst_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
    end else if (launch && first) begin
      cur <= ctrl.src_fwd ? src_ptr : dst_ptr;
    end else if (done && (ctrl.src_fwd || ctrl.dst_fwd)) begin
      cur <= cur + step;
    end
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  chan_ctrl_t    ctrl,
  input  logic          first,
  input  logic [CW-1:0] rld,
  input  logic [AW-1:0] rd_addr,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          done,
  output logic          launch,
  output logic          sgl_end,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_wide,
  output logic [DW-1:0] bus_wdata,
  output logic          irq
);

  localparam int HALF = DW / 2;

  phase_e        st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dq;
  logic          uflow;

  assign busy    = (st != PH_IDLE);
  assign done    = (st == PH_WRITE);
  assign launch  = start && (st == PH_IDLE) && ctrl.en;
  assign uflow   = (cnt == '0);
  assign sgl_end = done && uflow && !ctrl.rpt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PH_IDLE;
      cnt       <= '0;
      dq        <= '0;
      bus_addr  <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wide  <= 1'b0;
      bus_wdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        PH_IDLE: begin
          if (launch) begin
            if (first) cnt <= rld;
            bus_addr <= rd_addr;
            bus_rd   <= 1'b1;
            bus_wide <= ctrl.wide;
            st       <= PH_READ;
          end
        end
        PH_READ: begin
          bus_rd <= 1'b0;
          dq     <= bus_rdata;
          st     <= PH_HOLD;
        end
        PH_HOLD: begin
          bus_addr  <= wr_addr;
          bus_wr    <= 1'b1;
          bus_wdata <= ctrl.wide ? dq : {{(DW-HALF){1'b0}}, dq[HALF-1:0]};
          st        <= PH_WRITE;
        end
        default: begin
          bus_wr <= 1'b0;
          if (uflow) begin
            irq <= 1'b1;
            if (ctrl.rpt) cnt <= rld;
          end else begin
            cnt <= cnt - 1'b1;
          end
          st <= PH_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/dma_xfer_channel.sv
module dma_xfer_channel
  import dma_chan_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          start,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_wide,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          active,
  output logic          irq
);

  logic [AW-1:0] src_ptr;
  logic [AW-1:0] dst_ptr;
  logic [CW-1:0] rld;
  chan_ctrl_t    ctrl;
  logic          first;
  logic          done;
  logic          launch;
  logic          sgl_end;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] wr_addr;

  assign active = ctrl.en;

  dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .done(done), .sgl_end(sgl_end), .launch(launch),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .rld(rld),
    .ctrl(ctrl), .first(first)
  );

  dma_chan_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst),
    .launch(launch), .first(first), .done(done), .ctrl(ctrl),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .rd_addr(rd_addr), .wr_addr(wr_addr)
  );

  dma_chan_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .ctrl(ctrl), .first(first), .rld(rld),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .launch(launch), .sgl_end(sgl_end),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .irq(irq)
  );

endmodule

// File: rtl/dma_chan_sva.sv
module dma_chan_sva #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_wide,
  input logic [DW-1:0] bus_wdata,
  input logic          busy,
  input logic          active,
  input logic          irq
);

  localparam int HALF = DW / 2;

  assert_rd_then_hold_R1: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (!bus_rd && !bus_wr && busy));

  assert_wr_two_after_rd_R1: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd, 2) |-> bus_wr);

  assert_strobes_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  assert_no_launch_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !active) |=> !bus_rd);

  assert_no_launch_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !bus_wr) |=> !bus_rd);

  assert_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_wide) |-> (bus_wdata[DW-1:HALF] == '0));

  assert_wide_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !bus_rd) |-> $stable(bus_wide));

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_irq_after_wr_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(bus_wr));

endmodule

bind dma_xfer_channel dma_chan_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wide(bus_wide), .bus_wdata(bus_wdata), .busy(busy),
  .active(active), .irq(irq)
);

// File: tb/dma_xfer_channel_tb.sv
module dma_xfer_channel_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [19:0] wr_data = '0;
  logic        start = 1'b0;
  logic [19:0] bus_addr;
  logic        bus_rd, bus_wr, bus_wide, busy, active, irq;
  logic [15:0] bus_wdata, bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int irq_seen = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mem_val(input logic [19:0] a);
    return a[15:0] ^ 16'hA5C3 ^ {a[19:16], 12'h000};
  endfunction

  assign bus_rdata = mem_val(bus_addr);

  dma_xfer_channel u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .active(active), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [19:0] m_src, m_dst, m_cur, e_addr;
  logic [15:0] m_rel, m_cnt, m_dq, e_wdata;
  logic        m_en, m_wide, m_rpt, m_sf, m_df, m_first;
  logic        m_pv;
  logic [1:0]  m_psel;
  logic [19:0] m_pdata;
  int          m_ph;
  logic        e_rd, e_wr, e_wide, e_irq;

  task automatic m_apply(input logic [1:0] s, input logic [19:0] d);
    case (s)
      2'd0: m_src = d;
      2'd1: m_dst = d;
      2'd2: m_rel = d[15:0];
      default: if (!(d[3] && d[4])) begin
        if (d[0] && !m_en) m_first = 1'b1;
        m_en = d[0]; m_wide = d[1]; m_rpt = d[2]; m_sf = d[3]; m_df = d[4];
      end
    endcase
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_src = '0; m_dst = '0; m_cur = '0; e_addr = '0; m_rel = '0; m_cnt = '0;
      m_dq = '0; e_wdata = '0; m_en = 0; m_wide = 0; m_rpt = 0; m_sf = 0; m_df = 0;
      m_first = 0; m_pv = 0; m_psel = '0; m_pdata = '0; m_ph = 0;
      e_rd = 0; e_wr = 0; e_wide = 0; e_irq = 0;
    end else begin
      int  old_ph;
      logic clr;
      old_ph = m_ph;
      clr = 1'b0;
      e_irq = 1'b0;
      if (m_ph == 0) begin
        if (start && m_en) begin
          if (m_first) begin
            m_cur = m_sf ? m_src : m_dst;
            m_cnt = m_rel;
            m_first = 1'b0;
          end
          e_addr = m_sf ? m_cur : m_src;
          e_rd = 1'b1; e_wide = m_wide; m_ph = 1;
        end
      end else if (m_ph == 1) begin
        e_rd = 1'b0; m_dq = mem_val(e_addr); m_ph = 2;
      end else if (m_ph == 2) begin
        e_wr = 1'b1; e_addr = m_df ? m_cur : m_dst;
        e_wdata = m_wide ? m_dq : {8'h00, m_dq[7:0]}; m_ph = 3;
      end else begin
        e_wr = 1'b0;
        if (m_sf || m_df) m_cur = m_cur + (m_wide ? 20'd2 : 20'd1);
        if (m_cnt == 0) begin
          e_irq = 1'b1;
          if (m_rpt) m_cnt = m_rel; else clr = 1'b1;
        end else m_cnt = m_cnt - 1'b1;
        m_ph = 0;
      end
      if (clr) m_en = 1'b0;
      if (wr_en && (old_ph == 1 || old_ph == 2)) begin
        m_pv = 1'b1; m_psel = wr_sel; m_pdata = wr_data;
      end else begin
        if (wr_en) m_apply(wr_sel, wr_data);
        else if (old_ph == 3 && m_pv) m_apply(m_psel, m_pdata);
        if (old_ph == 3) m_pv = 1'b0;
      end
    end
  end

  // compare on the falling edge, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R1 bus_rd", 32'(bus_rd), 32'(e_rd));
      check("R1 bus_wr", 32'(bus_wr), 32'(e_wr));
      check("R1/R2 busy", 32'(busy), 32'(m_ph != 0));
      check("R3/R4 bus_addr", 32'(bus_addr), 32'(e_addr));
      check("R5 bus_wdata", 32'(bus_wdata), 32'(e_wdata));
      check("R5 bus_wide", 32'(bus_wide), 32'(e_wide));
      check("R6 irq", 32'(irq), 32'(e_irq));
      check("R7/R9 active", 32'(active), 32'(m_en));
      if (irq) irq_seen++;
    end
  end

  task automatic wreg(input logic [1:0] s, input logic [19:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic kick(input int gap);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < gap; i++) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc >= 20000);
    n_bad++;
    $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
    finish_up();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state, R1 and R7
    check("R1 reset bus_rd", 32'(bus_rd), 0);
    check("R1 reset busy", 32'(busy), 0);
    check("R7 reset active", 32'(active), 0);
    check("R6 reset irq", 32'(irq), 0);

    // R2: start while disabled is ignored
    kick(4);
    check("R2 start disabled", 32'(busy | bus_rd), 0);

    // R3/R4/R7: 16-bit, source forward, single mode, reload 2 -> 3 transfers
    wreg(2'd0, 20'h10000);
    wreg(2'd1, 20'h00400);
    wreg(2'd2, 20'd2);
    base = irq_seen;
    wreg(2'd3, 20'b01011);
    for (int k = 0; k < 4; k++) kick(5);
    check("R6 single irq count", 32'(irq_seen - base), 1);
    check("R7 single clears enable", 32'(active), 0);

    // R8: illegal control write with both forward bits ignored
    wreg(2'd3, 20'b11001);
    check("R8 illegal ctrl ignored", 32'(active), 0);
    kick(4);

    // R3/R4/R6/R7: 8-bit, destination forward, repeat, reload 1
    wreg(2'd0, 20'h0ABCD);
    wreg(2'd1, 20'hFFFFE);
    wreg(2'd2, 20'd1);
    base = irq_seen;
    wreg(2'd3, 20'b10101);
    for (int k = 0; k < 5; k++) kick(5);
    check("R6 repeat irq count", 32'(irq_seen - base), 2);
    check("R7 repeat stays enabled", 32'(active), 1);

    // R2: start held high gives back-to-back transfers, no overlap
    @(negedge clk); start = 1'b1;
    repeat (9) @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);

    // R9: disable written during a transfer takes effect at its end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; wr_en = 1'b1; wr_sel = 2'd3; wr_data = 20'b00000;
    @(negedge clk); wr_en = 1'b0;
    check("R9 write deferred while busy", 32'(active), 1);
    repeat (3) @(negedge clk);
    check("R9 disable applied after transfer", 32'(active), 0);
    kick(4);
    check("R9 stopped channel ignores start", 32'(busy), 0);

    // R3: re-enable reloads working pointer; 16-bit source forward repeat at wrap
    wreg(2'd0, 20'hFFFFE);
    wreg(2'd1, 20'h00020);
    wreg(2'd2, 20'd0);
    wreg(2'd3, 20'b01111);
    for (int k = 0; k < 3; k++) kick(5);
    wreg(2'd3, 20'b00000);
    wreg(2'd3, 20'b01111);
    kick(5);
    // both fixed, 8-bit
    wreg(2'd3, 20'b00000);
    wreg(2'd3, 20'b00101);
    for (int k = 0; k < 2; k++) kick(5);
    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule